// File: doc/BRIEF.md
# Four-Channel Buffered Pulse Width Modulator

This block produces four independent pulse width modulated outputs from one input clock. Each channel divides the clock by a power of two. It counts through a programmable period and drives its pin inactive for the first part of the period and active for the rest. The polarity setting picks which pin level counts as inactive. Software controls the block through a small memory-mapped interface with separate write and read strobes. Read data is returned one cycle after the read strobe.

Duty and period changes made while a channel is running go through next-value registers. These are copied into the working registers only when the current period ends, so the waveform never shows a truncated or stretched pulse. Starting and stopping use separate write-one-to-act registers. A stop request lets the current period finish, and the status bit stays set until then. A per-channel end-of-period flag register lets software tell when a period has completed. Reading that register clears it.

Top module: `pwm_quad_ctrl`

## Requirements
- R1: After reset every channel is stopped, every output is low, and the status, flag, mode, duty, period and next-value registers all read 0.
- R2: Writing 1 to bit c of the start register (offset 0x04) starts stopped channel c. Its status bit (offset 0x0C, bit c) reads 1, and its count restarts at 0 with the prescaler phase at 0. A start aimed at a running channel has no effect.
- R3: Mode register bits [3:0] hold the prescale exponent N, and the period count advances once every 2^N clocks. A written value above 10 is stored as 10.
- R4: With period P and duty D, a running channel spends counts 0..D-1 of each period inactive and counts D..P-1 active. When D >= P the output stays inactive. A period of 0 behaves like a period of 1. Mode bit 9 set means the inactive level is high; clear means the inactive level is low.
- R5: A value written to the duty-next (sub-offset 0x08) or period-next (sub-offset 0x10) register is copied into the working duty (0x04) or period (0x0C) register only at the end of a period. A direct duty write takes effect on the next cycle.
- R6: Writes to the mode register or the direct period register of a running channel are ignored.
- R7: Writing 1 to bit c of the stop register (offset 0x08) lets a running channel finish its current period. The status bit stays 1 until that period ends and then reads 0.
- R8: Flag register (offset 0x1C) bit c is set when channel c completes a period. A read returns the flags and clears them all, but a flag set in the same cycle as that read is kept.
- R9: Read data is valid in the cycle after the read strobe. Channel c registers sit at 0x200 + 0x20*c. Unmapped addresses and the start and stop registers read as 0.
- R10: A stopped channel drives its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 10 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, valid one cycle after busRdEn |
| pwmOut | output | 4 | Channel waveforms, bit c for channel c |

## Verification
The embedded properties are checked on every cycle. They cover these rules:
- mode and period stay fixed while a channel runs, except for a load at a period end;
- the working duty changes only through a direct write or a period-end load;
- a channel stops only at a period end after a stop request;
- a start clears the count and the prescaler phase;
- the stored prescale value stays in its legal range;
- every period end sets the matching flag.

Waveform shape, polarity, prescaled timing, flag clearing on a read that races a new flag, and readback values need whole scenarios. The bench runs them against a cycle-by-cycle behavioural model.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  // Global register offsets (software-visible map).
  localparam int unsigned OFS_START     = 'h04;
  localparam int unsigned OFS_STOP      = 'h08;
  localparam int unsigned OFS_STAT      = 'h0C;
  localparam int unsigned OFS_FLAG      = 'h1C;

  // Per-channel register window.
  localparam int unsigned OFS_CH_BASE   = 'h200;
  localparam int unsigned OFS_CH_STRIDE = 'h20;

  // Offsets within one channel window.
  localparam int unsigned OFS_MODE      = 'h00;
  localparam int unsigned OFS_DUTY      = 'h04;
  localparam int unsigned OFS_DUTY_NXT  = 'h08;
  localparam int unsigned OFS_PER       = 'h0C;
  localparam int unsigned OFS_PER_NXT   = 'h10;

  // Mode register field position.
  localparam int unsigned MODE_POL_BIT  = 9;

  // Per-channel strobes from control to datapath.
  typedef struct packed {
    logic start;
    logic stop;
    logic wrMode;
    logic wrDuty;
    logic wrDutyNext;
    logic wrPer;
    logic wrPerNext;
  } chanStrobe_t;

endpackage

// File: rtl/pwm_quad_ctl.sv
module pwm_quad_ctl
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int PRESC_W = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic                            busWrEn,
  input  logic [NUM_CH-1:0]               wrMask,
  input  logic                            busRdEn,
  output logic [DATA_W-1:0]               busRdData,
  output chanStrobe_t [NUM_CH-1:0]        strobes,
  input  logic [NUM_CH-1:0]               chRunning,
  input  logic [NUM_CH-1:0][PRESC_W-1:0]  chPresc,
  input  logic [NUM_CH-1:0]               chPol,
  input  logic [NUM_CH-1:0][CNT_W-1:0]    chDuty,
  input  logic [NUM_CH-1:0][CNT_W-1:0]    chDutyNext,
  input  logic [NUM_CH-1:0][CNT_W-1:0]    chPer,
  input  logic [NUM_CH-1:0][CNT_W-1:0]    chPerNext,
  input  logic [NUM_CH-1:0]               chEnd
);

  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SUB_W    = $clog2(OFS_CH_STRIDE);
  localparam int SPAN     = NUM_CH * OFS_CH_STRIDE;

  logic [ADDR_W-1:0]   relAddr;
  logic                inChan;
  logic [CH_IDX_W-1:0] chSel;
  logic [SUB_W-1:0]    subOfs;
  logic                flagRd;
  logic [NUM_CH-1:0]   flags;
  logic [DATA_W-1:0]   rdNext;

  assign relAddr = busAddr - ADDR_W'(OFS_CH_BASE);
  assign inChan  = (busAddr >= ADDR_W'(OFS_CH_BASE)) && (relAddr < ADDR_W'(SPAN));
  assign chSel   = relAddr[SUB_W +: CH_IDX_W];
  assign subOfs  = relAddr[SUB_W-1:0];
  assign flagRd  = busRdEn && (busAddr == ADDR_W'(OFS_FLAG));

  // Strobe generation, one set per channel.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
    logic chHit;
    assign chHit = busWrEn && inChan && (chSel == CH_IDX_W'(c));
    assign strobes[c].start      = busWrEn && (busAddr == ADDR_W'(OFS_START)) && wrMask[c];
    assign strobes[c].stop       = busWrEn && (busAddr == ADDR_W'(OFS_STOP)) && wrMask[c];
    assign strobes[c].wrMode     = chHit && (subOfs == SUB_W'(OFS_MODE));
    assign strobes[c].wrDuty     = chHit && (subOfs == SUB_W'(OFS_DUTY));
    assign strobes[c].wrDutyNext = chHit && (subOfs == SUB_W'(OFS_DUTY_NXT));
    assign strobes[c].wrPer      = chHit && (subOfs == SUB_W'(OFS_PER));
    assign strobes[c].wrPerNext  = chHit && (subOfs == SUB_W'(OFS_PER_NXT));
  end

  // Read multiplexer.
  always_comb begin
    rdNext = '0;
    if (busAddr == ADDR_W'(OFS_STAT)) begin
      rdNext[NUM_CH-1:0] = chRunning;
    end else if (busAddr == ADDR_W'(OFS_FLAG)) begin
      rdNext[NUM_CH-1:0] = flags;
    end else if (inChan) begin
      case (subOfs)
        SUB_W'(OFS_MODE): begin
          rdNext[PRESC_W-1:0]  = chPresc[chSel];
          rdNext[MODE_POL_BIT] = chPol[chSel];
        end
        SUB_W'(OFS_DUTY):     rdNext[CNT_W-1:0] = chDuty[chSel];
        SUB_W'(OFS_DUTY_NXT): rdNext[CNT_W-1:0] = chDutyNext[chSel];
        SUB_W'(OFS_PER):      rdNext[CNT_W-1:0] = chPer[chSel];
        SUB_W'(OFS_PER_NXT):  rdNext[CNT_W-1:0] = chPerNext[chSel];
        default:              rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags     <= '0;
      busRdData <= '0;
    end else begin
      flags     <= (flagRd ? '0 : flags) | chEnd;
      busRdData <= busRdEn ? rdNext : '0;
    end
  end

  // R8: every period end leaves its flag set on the next cycle.
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    (|chEnd) |=> ((flags & $past(chEnd)) == $past(chEnd)));

  // R8: a clearing read with no new period end empties the flags.
  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    (flagRd && !(|chEnd)) |=> (flags == '0));

endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
  import pwm_quad_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PRESC_MAX = 10,
  parameter int PRESC_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  chanStrobe_t        strobe,
  input  logic [CNT_W-1:0]   wrCnt,
  input  logic [PRESC_W-1:0] wrPresc,
  input  logic               wrPol,
  output logic               running,
  output logic [PRESC_W-1:0] presc,
  output logic               pol,
  output logic [CNT_W-1:0]   duty,
  output logic [CNT_W-1:0]   dutyNext,
  output logic [CNT_W-1:0]   per,
  output logic [CNT_W-1:0]   perNext,
  output logic               endPulse,
  output logic               pwmOut
);

  localparam int PRE_CNT_W = (PRESC_MAX > 0) ? PRESC_MAX : 1;

  logic [PRE_CNT_W-1:0] preCnt;
  logic [PRE_CNT_W-1:0] preMask;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W:0]       cntInc;
  logic                 stopPend;
  logic                 dutyPend;
  logic                 perPend;
  logic                 tick;
  logic                 wrap;
  logic [PRESC_W-1:0]   prescLegal;

  always_comb preMask = PRE_CNT_W'((33'd1 << presc) - 33'd1);

  assign tick       = (preCnt == preMask);
  assign cntInc     = {1'b0, cnt} + 1'b1;
  assign wrap       = (cntInc >= {1'b0, per});
  assign endPulse   = running && tick && wrap;
  assign prescLegal = (wrPresc > PRESC_W'(PRESC_MAX)) ? PRESC_W'(PRESC_MAX) : wrPresc;
  assign pwmOut     = (running && (cnt >= duty)) ? ~pol : pol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      stopPend <= 1'b0;
      preCnt   <= '0;
      cnt      <= '0;
      presc    <= '0;
      pol      <= 1'b0;
      duty     <= '0;
      dutyNext <= '0;
      dutyPend <= 1'b0;
      per      <= '0;
      perNext  <= '0;
      perPend  <= 1'b0;
    end else begin
      // Run control and counting.
      if (strobe.start && !running) begin
        running  <= 1'b1;
        stopPend <= 1'b0;
        cnt      <= '0;
        preCnt   <= '0;
      end else if (running) begin
        preCnt <= tick ? '0 : preCnt + 1'b1;
        if (tick) cnt <= wrap ? '0 : cntInc[CNT_W-1:0];
        if (endPulse && stopPend) begin
          running  <= 1'b0;
          stopPend <= 1'b0;
        end else if (strobe.stop) begin
          stopPend <= 1'b1;
        end
      end

      // Mode: only while stopped.
      if (strobe.wrMode && !running) begin
        presc <= prescLegal;
        pol   <= wrPol;
      end

      // Duty: direct write now, buffered value at period end.
      if (strobe.wrDuty) duty <= wrCnt;
      else if (endPulse && dutyPend) duty <= dutyNext;

      if (strobe.wrDutyNext) begin
        dutyNext <= wrCnt;
        dutyPend <= 1'b1;
      end else if (endPulse) begin
        dutyPend <= 1'b0;
      end

      // Period: direct write only while stopped, buffered value at period end.
      if (strobe.wrPer && !running) per <= wrCnt;
      else if (endPulse && perPend) per <= perNext;

      if (strobe.wrPerNext) begin
        perNext <= wrCnt;
        perPend <= 1'b1;
      end else if (endPulse) begin
        perPend <= 1'b0;
      end
    end
  end

  // R2: a start leaves the count and prescaler phase at zero.
  a_r2_start_clean: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> ((cnt == '0) && (preCnt == '0)));

  // R3: the stored prescale exponent never exceeds its limit.
  a_r3_presc_legal: assert property (@(posedge clk) disable iff (!rstN)
    presc <= PRESC_W'(PRESC_MAX));

  // R6: mode fields hold while the channel keeps running.
  a_r6_mode_locked: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running)) |-> ($stable(presc) && $stable(pol)));

  // R6 / R5: period changes while running only through a period-end load.
  a_r6_per_locked: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && !$past(endPulse)) |-> $stable(per));

  // R5: working duty changes only by direct write or period-end load.
  a_r5_duty_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(endPulse) && !$past(strobe.wrDuty)) |-> $stable(duty));

  // R7: a channel stops only at a period end after a stop request.
  a_r7_stop_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> ($past(endPulse) && $past(stopPend)));

endmodule

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int PRESC_MAX = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_CH-1:0] pwmOut
);

  localparam int PRESC_W = $clog2(PRESC_MAX + 1);

  chanStrobe_t [NUM_CH-1:0]        strobes;
  logic [NUM_CH-1:0]               chRunning;
  logic [NUM_CH-1:0][PRESC_W-1:0]  chPresc;
  logic [NUM_CH-1:0]               chPol;
  logic [NUM_CH-1:0][CNT_W-1:0]    chDuty;
  logic [NUM_CH-1:0][CNT_W-1:0]    chDutyNext;
  logic [NUM_CH-1:0][CNT_W-1:0]    chPer;
  logic [NUM_CH-1:0][CNT_W-1:0]    chPerNext;
  logic [NUM_CH-1:0]               chEnd;
  logic                            unusedWrBits;

  assign unusedWrBits = ^busWrData;

  pwm_quad_ctl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CNT_W(CNT_W), .PRESC_W(PRESC_W)
  ) ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .wrMask     (busWrData[NUM_CH-1:0]),
    .busRdEn    (busRdEn),
    .busRdData  (busRdData),
    .strobes    (strobes),
    .chRunning  (chRunning),
    .chPresc    (chPresc),
    .chPol      (chPol),
    .chDuty     (chDuty),
    .chDutyNext (chDutyNext),
    .chPer      (chPer),
    .chPerNext  (chPerNext),
    .chEnd      (chEnd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_quad_chan #(
      .CNT_W(CNT_W), .PRESC_MAX(PRESC_MAX), .PRESC_W(PRESC_W)
    ) chan_i (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobes[c]),
      .wrCnt    (busWrData[CNT_W-1:0]),
      .wrPresc  (busWrData[PRESC_W-1:0]),
      .wrPol    (busWrData[MODE_POL_BIT]),
      .running  (chRunning[c]),
      .presc    (chPresc[c]),
      .pol      (chPol[c]),
      .duty     (chDuty[c]),
      .dutyNext (chDutyNext[c]),
      .per      (chPer[c]),
      .perNext  (chPerNext[c]),
      .endPulse (chEnd[c]),
      .pwmOut   (pwmOut[c])
    );
  end

endmodule

// File: tb/pwm_quad_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwm_quad_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic [3:0]  pwmOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_quad_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .pwmOut(pwmOut)
  );

  // Behavioural reference model.
  int mRun[4], mStop[4], mPre[4], mCnt[4], mPsc[4], mPol[4];
  int mDuty[4], mDutyN[4], mPer[4], mPerN[4], mPendD[4], mPendP[4];
  int mFlags;
  int expRd;
  bit rdChk = 1'b0;
  string rdTag = "";

  function automatic int modelRead(int a);
    int rel, c, s, v;
    v = 0;
    if (a == 'h0C) begin
      for (int k = 0; k < 4; k++) if (mRun[k] != 0) v |= (1 << k);
    end else if (a == 'h1C) begin
      v = mFlags;
    end else if (a >= 'h200 && a < 'h280) begin
      rel = a - 'h200; c = rel / 32; s = rel % 32;
      case (s)
        'h00: v = mPsc[c] | (mPol[c] << 9);
        'h04: v = mDuty[c];
        'h08: v = mDutyN[c];
        'h0C: v = mPer[c];
        'h10: v = mPerN[c];
        default: v = 0;
      endcase
    end
    return v;
  endfunction

  always @(posedge clk) begin
    int endv, a, d, base, sub, mask;
    bit flagRd, tick, bnd, r, hit, wrS, wrP;
    if (!rstN) begin
      for (int c = 0; c < 4; c++) begin
        mRun[c] = 0; mStop[c] = 0; mPre[c] = 0; mCnt[c] = 0; mPsc[c] = 0; mPol[c] = 0;
        mDuty[c] = 0; mDutyN[c] = 0; mPer[c] = 0; mPerN[c] = 0; mPendD[c] = 0; mPendP[c] = 0;
      end
      mFlags = 0; rdChk = 1'b0;
    end else begin
      a = int'(busAddr); d = int'(busWrData);
      rdChk  = busRdEn;
      expRd  = busRdEn ? modelRead(a) : 0;
      flagRd = busRdEn && (a == 'h1C);
      endv = 0;
      for (int c = 0; c < 4; c++) begin
        mask = (1 << mPsc[c]) - 1;
        tick = (mPre[c] == mask);
        bnd  = (mRun[c] != 0) && tick && (mCnt[c] + 1 >= mPer[c]);
        if (bnd) endv |= (1 << c);
        r    = (mRun[c] != 0);
        wrS  = busWrEn && (a == 'h04) && busWrData[c];
        wrP  = busWrEn && (a == 'h08) && busWrData[c];
        base = 'h200 + c * 'h20;
        hit  = busWrEn && (a >= base) && (a < base + 'h20);
        sub  = a - base;
        if (wrS && !r) begin
          mRun[c] = 1; mStop[c] = 0; mCnt[c] = 0; mPre[c] = 0;
        end else if (r) begin
          if (tick) begin
            mPre[c] = 0;
            mCnt[c] = (mCnt[c] + 1 >= mPer[c]) ? 0 : mCnt[c] + 1;
          end else begin
            mPre[c] = mPre[c] + 1;
          end
          if (bnd && mStop[c] != 0) begin mRun[c] = 0; mStop[c] = 0; end
          else if (wrP) mStop[c] = 1;
        end
        if (hit && sub == 'h00 && !r) begin
          mPsc[c] = ((d & 15) > 10) ? 10 : (d & 15);
          mPol[c] = (d >> 9) & 1;
        end
        if (hit && sub == 'h04) mDuty[c] = d & 'hFFFF;
        else if (bnd && mPendD[c] != 0) mDuty[c] = mDutyN[c];
        if (hit && sub == 'h08) begin mDutyN[c] = d & 'hFFFF; mPendD[c] = 1; end
        else if (bnd) mPendD[c] = 0;
        if (hit && sub == 'h0C && !r) mPer[c] = d & 'hFFFF;
        else if (bnd && mPendP[c] != 0) mPer[c] = mPerN[c];
        if (hit && sub == 'h10) begin mPerN[c] = d & 'hFFFF; mPendP[c] = 1; end
        else if (bnd) mPendP[c] = 0;
      end
      mFlags = (flagRd ? 0 : mFlags) | endv;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Compare outputs every clock, away from the active edge.
  always @(negedge clk) begin
    bit e;
    if (!done) begin
      for (int c = 0; c < 4; c++) begin
        e = ((mRun[c] != 0) && (mCnt[c] >= mDuty[c])) ? (mPol[c] == 0) : (mPol[c] != 0);
        check(pwmOut[c] === e, $sformatf("R4/R10 output ch%0d t=%0t", c, $time),
              longint'(pwmOut[c]), longint'(e));
      end
      if (rdChk) begin
        check(busRdData === expRd, rdTag, longint'(busRdData), longint'(expRd));
        rdChk = 1'b0;
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    busAddr = 10'(a); busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    busAddr = 10'(a); busRdEn = 1'b1; rdTag = tag;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1: reset state
    rd('h0C, "R1 status after reset");
    rd('h1C, "R1 flags after reset");
    rd('h200, "R1 mode ch0 after reset");
    rd('h26C, "R1 period ch3 after reset");
    // R3: prescale above limit is stored as limit; polarity bit 9
    wr('h200, 'h20F);
    rd('h200, "R3 mode clamp ch0");
    // Configure channels
    wr('h200, 'h001); wr('h20C, 5); wr('h204, 2);           // ch0 N=1 P=5 D=2
    wr('h220, 'h200); wr('h22C, 4); wr('h224, 1);           // ch1 inverted, P=4 D=1
    wr('h240, 'h002); wr('h24C, 3); wr('h244, 3);           // ch2 D>=P
    wr('h260, 'h000); wr('h26C, 1); wr('h264, 0);           // ch3 always active
    idle(4);
    // R2: start all
    wr('h04, 'hF);
    rd('h0C, "R2 status after start");
    idle(40);
    // R2: start on running channel ignored
    wr('h04, 'h1);
    rd('h0C, "R2 status after repeated start");
    idle(10);
    // R6: mode and period writes ignored while running
    wr('h200, 'h203);
    rd('h200, "R6 mode ch0 unchanged while running");
    wr('h20C, 9);
    rd('h20C, "R6 period ch0 unchanged while running");
    // R5: buffered updates
    wr('h228, 3); wr('h230, 6);
    rd('h224, "R5 duty ch1 before period end");
    rd('h22C, "R5 period ch1 before period end");
    rd('h228, "R5 duty-next ch1 readback");
    idle(12);
    rd('h224, "R5 duty ch1 after period end");
    rd('h22C, "R5 period ch1 after period end");
    wr('h204, 4);
    rd('h204, "R5 direct duty ch0");
    idle(20);
    // R8: flag set concurrent with clearing read is kept (ch3 ends every cycle)
    rd('h1C, "R8 flags read");
    rd('h1C, "R8 flags reread with racing set");
    // R7: stop waits for period end
    wr('h08, 'h2);
    rd('h0C, "R7 status just after stop");
    idle(30);
    rd('h0C, "R7 status after period end");
    wr('h08, 'hF);
    idle(60);
    rd('h0C, "R7 status all stopped");
    rd('h1C, "R8 flags before clear");
    rd('h1C, "R8 flags after clear");
    // R9: unmapped and write-only registers read zero
    rd('h100, "R9 unmapped read");
    rd('h04, "R9 start register read");
    rd('h2A0, "R9 beyond channel window");
    rd('h214, "R9 unused channel sub-offset");
    // R3: largest prescale with period 2
    wr('h200, 'h00A); wr('h20C, 2); wr('h204, 1);
    rd('h200, "R3 mode ch0 N=10");
    wr('h04, 'h1);
    idle(1000);
    rd('h1C, "R3 no period end yet at N=10");
    idle(1100);
    rd('h1C, "R3 period end at N=10");
    wr('h08, 'h1);
    idle(2200);
    rd('h0C, "R10 ch0 stopped");
    idle(5);
    finishRun();
  end

endmodule